// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is an interval timer for a small controller. An 8-bit counter counts down by one step on each pulse taken from a 7-bit binary prescaler. A 3-bit code picks which prescaler output drives the counter, giving the system clock divided by any power of two from 1 to 128. Software writes the counter directly to preset it. When the counter steps down to zero, a sticky flag is set. The flag, gated by a mask bit, forms the interrupt request sent to the processor.

Two byte-wide registers sit on a simple register bus: the live count and a control register. The control register holds the following fields:

- the flag in bit 7;
- the request mask in bit 6;
- a write-only prescaler-clear strobe in bit 3;
- the tap select code in bits 2:0.

Software writes the clear strobe before it starts a measured interval, so the first count has full length. A clock-enable input freezes the prescaler and the counter during low-power states. Register writes still work while it is low.

Top module: `dntmr_top`

## Requirements
- R1: After reset the count reads 0xFF, the control register reads 0x44 (flag 0, mask 1, select 100), and the request output is 0.
- R2: A write to the count address loads the written byte on that clock edge. The load takes priority over a prescaled tick in the same cycle, and the next tick decrements from the loaded value.
- R3: Select code s in control bits 2:0 (0 to 7) makes the counter step once every 2^s enabled clocks.
- R4: Control bit 7 is set when a tick takes the count from 1 to 0. It stays set until reset or until a control write with bit 7 equal to 0. Writing 1 to bit 7 leaves it unchanged.
- R5: If a control write clears bit 7 in the same cycle as a zero event, the flag stays set.
- R6: A tick at count 0 wraps the count to 0xFF without setting the flag.
- R7: The request output equals flag AND NOT mask, where the mask is control bit 6. The mask affects neither counting nor the setting of the flag.
- R8: Writing 1 to control bit 3 zeroes the prescaler and suppresses the tick in that cycle. The next tick comes exactly 2^s enabled clocks later, and bit 3 always reads 0.
- R9: While the clock enable is low, the prescaler and counter hold, and the count can be read without disturbing it.
- R10: Control bits 5 and 4 read 0 whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Counting enable for prescaler and counter |
| bus_addr | input | ADDR_W | Register address (0 count, 1 control) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for the addressed register |
| irq_req | output | 1 | Timer interrupt request |

## Verification
Some checks run on every cycle:

- a load lands exactly, and a load wins over a tick;
- the count wraps from 0 to all ones;
- the count holds when no tick and no load occur;
- the prescaler is zeroed by the clear strobe and frozen while the enable is low;
- the flag is sticky, is set by every zero event (a colliding clear write included), and cannot rise without one.

Other properties need the bench's scenarios:

- the exact division ratio for each select code;
- the count after an interval with no truncation after a prescaler clear;
- the read-back layout of the control register;
- the masking of the request.

// File: rtl/dntmr_pkg.sv
package dntmr_pkg;
   // control register field positions (software decodes these)
   localparam int CTL_FLAG_BIT = 7;
   localparam int CTL_MASK_BIT = 6;
   localparam int CTL_CLR_BIT  = 3;
   localparam int CTL_MIN_W    = 8;

   typedef enum logic [0:0] {
      REG_COUNT = 1'b0,
      REG_CTRL  = 1'b1
   } dntmr_reg_e;
endpackage

// File: rtl/dntmr_prescaler.sv
module dntmr_prescaler #(
   parameter int PSC_W = 7,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int NTAP = 1 << SEL_W;

   logic [PSC_W-1:0] psc_q;
   logic [NTAP-1:0]  taps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         psc_q <= '0;
      else if (clr)
         psc_q <= '0;
      else if (clk_en)
         psc_q <= psc_q + 1'b1;
   end

   // tap k fires when the low k prescaler bits are all ones (period 2^k)
   for (genvar k = 0; k < NTAP; k++) begin : g_tap
      if (k == 0) begin : g_direct
         assign taps[k] = 1'b1;
      end else if (k <= PSC_W) begin : g_div
         assign taps[k] = &psc_q[k-1:0];
      end else begin : g_clip
         assign taps[k] = &psc_q;
      end
   end

   assign tick = clk_en & ~clr & taps[sel];

   a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (psc_q == '0));
   a_r9_freeze_prescaler: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en && !clr) |=> $stable(psc_q));
endmodule

// File: rtl/dntmr_counter.sv
module dntmr_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             zero_evt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '1;
      else if (load)
         cnt_q <= load_val;
      else if (tick)
         cnt_q <= cnt_q - 1'b1;
   end

   assign count    = cnt_q;
   assign zero_evt = tick & ~load & (cnt_q == ONE);

   a_r2_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));
   a_r6_wrap_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt_q == '0) |=> (cnt_q == '1));
   a_r9_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/dntmr_ctrl.sv
module dntmr_ctrl
   import dntmr_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SEL_W   = 3,
   parameter int RST_SEL = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl,
   input  logic [DATA_W-1:0] wdata,
   input  logic              zero_evt,
   output logic              flag,
   output logic              mask,
   output logic [SEL_W-1:0]  sel,
   output logic              psc_clr,
   output logic [DATA_W-1:0] ctl_rd
);
   logic             flag_q, mask_q;
   logic [SEL_W-1:0] sel_q;
   logic             unused_wdata;

   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         mask_q <= 1'b1;
         sel_q  <= SEL_W'(RST_SEL);
      end else begin
         if (zero_evt)
            flag_q <= 1'b1;
         else if (wr_ctl && !wdata[CTL_FLAG_BIT])
            flag_q <= 1'b0;
         if (wr_ctl) begin
            mask_q <= wdata[CTL_MASK_BIT];
            sel_q  <= wdata[SEL_W-1:0];
         end
      end
   end

   assign psc_clr = wr_ctl & wdata[CTL_CLR_BIT];
   assign flag    = flag_q;
   assign mask    = mask_q;
   assign sel     = sel_q;

   always_comb begin
      ctl_rd               = '0;
      ctl_rd[CTL_FLAG_BIT] = flag_q;
      ctl_rd[CTL_MASK_BIT] = mask_q;
      ctl_rd[SEL_W-1:0]    = sel_q;
   end

   a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(wr_ctl && !wdata[CTL_FLAG_BIT])) |=> flag_q);
   a_r4_flag_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !zero_evt) |=> !flag_q);
   a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> flag_q);
endmodule

// File: rtl/dntmr_top.sv
module dntmr_top
   import dntmr_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int PSC_W    = 7,
   parameter int ADDR_W   = 1,
   parameter int CNT_ADDR = 0,
   parameter int CTL_ADDR = 1,
   parameter int RST_SEL  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq_req
);
   localparam int SEL_W = $clog2(PSC_W + 1);
   localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CNT_ADDR);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);

   // elaboration-time parameter checks
   if (CNT_W < CTL_MIN_W) begin : g_bad_width
      $error("dntmr_top: CNT_W must be at least %0d", CTL_MIN_W);
   end
   if (SEL_W > CTL_CLR_BIT) begin : g_bad_sel
      $error("dntmr_top: select field would overlap the clear bit");
   end
   if (PSC_W < 1) begin : g_bad_psc
      $error("dntmr_top: PSC_W must be positive");
   end
   if (CNT_ADDR == CTL_ADDR) begin : g_bad_map
      $error("dntmr_top: register addresses collide");
   end

   logic             sel_cnt, sel_ctl;
   logic             tick, psc_clr, zero_evt;
   logic             flag, mask;
   logic [SEL_W-1:0] sel;
   logic [CNT_W-1:0] count, ctl_rd;
   dntmr_reg_e       rsel;

   assign sel_cnt = (bus_addr == A_CNT);
   assign sel_ctl = (bus_addr == A_CTL);

   dntmr_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clk_en (clk_en),
      .clr    (psc_clr),
      .sel    (sel),
      .tick   (tick)
   );

   dntmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (bus_wr & sel_cnt),
      .load_val (bus_wdata),
      .count    (count),
      .zero_evt (zero_evt)
   );

   dntmr_ctrl #(.DATA_W(CNT_W), .SEL_W(SEL_W), .RST_SEL(RST_SEL)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctl   (bus_wr & sel_ctl),
      .wdata    (bus_wdata),
      .zero_evt (zero_evt),
      .flag     (flag),
      .mask     (mask),
      .sel      (sel),
      .psc_clr  (psc_clr),
      .ctl_rd   (ctl_rd)
   );

   always_comb begin
      rsel = sel_ctl ? REG_CTRL : REG_COUNT;
      if (!sel_cnt && !sel_ctl)
         bus_rdata = '0;
      else if (rsel == REG_CTRL)
         bus_rdata = ctl_rd;
      else
         bus_rdata = count;
   end

   assign irq_req = flag & ~mask;

   a_r7_request_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && !mask) |=> irq_req);
endmodule

// File: tb/sim_dntmr_top.sv
module sim_dntmr_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // columns: select, preset, idle clocks, expected count, expected flag
   localparam int VEC [NVEC][5] = '{
      '{0, 10,   5,   5, 0},
      '{1, 10,   7,   7, 0},
      '{2,  3,  12,   0, 1},
      '{3,  2,  24, 255, 1},
      '{4, 100, 50,  97, 0},
      '{5,  1,  31,   1, 0},
      '{6,  1,  64,   0, 1},
      '{7,  5, 300,   3, 0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_en = 1'b1;
   logic [0:0] bus_addr = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq_req;

   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;

   dntmr_top u0 (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_req(irq_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int v;
      idle(3);
      rst_n = 1'b1;
      // R1 reset values
      rd(1'b0, v); check("R1 count reset", v, 8'hFF);
      rd(1'b1, v); check("R1 control reset", v, 8'h44);
      check("R1 request reset", int'(irq_req), 0);

      // R3 division ratios, R4/R7 flag with mask set, R6 wrap
      for (int i = 0; i < NVEC; i++) begin
         wr(1'b0, 8'(VEC[i][1]));
         wr(1'b1, 8'(8'h48 | VEC[i][0]));
         idle(VEC[i][2]);
         rd(1'b0, v); check("R3 count after interval", v, VEC[i][3]);
         rd(1'b1, v); check("R4 R7 flag after interval", (v >> 7) & 1, VEC[i][4]);
         check("R7 masked request", int'(irq_req), 0);
      end

      // R5 clear write colliding with zero event
      wr(1'b1, 8'h48);
      wr(1'b0, 8'd2);
      idle(1);
      wr(1'b1, 8'h40);
      rd(1'b1, v); check("R5 event wins over clear", v, 8'hC0);
      rd(1'b0, v); check("R5 count at zero", v, 0);
      // R6 wrap without flag
      wr(1'b1, 8'h47);
      rd(1'b0, v); check("R6 wrap to all ones", v, 8'hFF);
      rd(1'b1, v); check("R6 no flag on wrap", v, 8'h47);

      // R4 writing 1 to flag is no-op, R7 request gating
      wr(1'b1, 8'h48);
      wr(1'b0, 8'd1);
      idle(1);
      rd(1'b1, v); check("R4 flag set at zero", v, 8'hC0);
      wr(1'b1, 8'hC7);
      rd(1'b1, v); check("R4 write 1 keeps flag", v, 8'hC7);
      check("R7 mask blocks request", int'(irq_req), 0);
      wr(1'b1, 8'h87);
      check("R7 request when unmasked", int'(irq_req), 1);
      wr(1'b1, 8'h07);
      rd(1'b1, v); check("R4 write 0 clears flag", v, 8'h07);
      check("R7 request drops", int'(irq_req), 0);

      // R8 prescaler clear gives full first interval
      wr(1'b0, 8'd50);
      wr(1'b1, 8'h4A);
      idle(3);
      rd(1'b0, v); check("R8 no tick before 4 clocks", v, 50);
      idle(1);
      rd(1'b0, v); check("R8 tick at 4th clock", v, 49);
      rd(1'b1, v); check("R8 clear bit reads 0", v, 8'h42);

      // R2 load wins over tick
      wr(1'b1, 8'h48);
      idle(2);
      wr(1'b0, 8'd9);
      rd(1'b0, v); check("R2 load over tick", v, 9);
      idle(1);
      rd(1'b0, v); check("R2 decrement from load", v, 8);

      // R9 clock enable freeze
      wr(1'b1, 8'h48);
      clk_en = 1'b0;
      wr(1'b0, 8'd20);
      idle(10);
      rd(1'b0, v); check("R9 frozen count", v, 20);
      clk_en = 1'b1;
      idle(3);
      rd(1'b0, v); check("R9 resumes counting", v, 17);

      // R10 bits 5 and 4 read 0
      wr(1'b1, 8'hFF);
      rd(1'b1, v); check("R10 reserved bits read 0", v, 8'h47);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule